// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate with Output Quantization

This block is the arithmetic core of a signal-processing datapath. It takes two signed 16-bit two's-complement operands, forms their full 32-bit product and adds it to, or subtracts it from, a 40-bit accumulator. The accumulator holds eight guard bits above the double-precision product. Operands may be integers or fractions. The hardware does not care where the binary point sits. A fractional-mode control doubles the product by shifting it left one place, which drops the redundant second sign bit that a signed fractional multiply produces.

Each cycle an output stage reduces the accumulator to a 16-bit result. It takes accumulator bits 31 down to 16 and discards the 16 bits below them using the selected quantization rule. If the quantized value does not fit in 16 signed bits, the selected overflow rule decides the result. The result and an overflow flag are registered. A filter loop uses the block by issuing one load (clear) strobe and then one accumulate strobe per tap. It then reads the quantized sum two cycles after the last strobe.

Top module: `fxp_mac_quant`

## Requirements
- R1: While reset is asserted and after it is released, `res` is 0, `ovf` is 0 and the accumulator is 0.
- R2: With `clr` high, the accumulator loads the sign-extended product `op_a*op_b` of the signed operands in place of its old contents. `clr` takes priority over `acc_en`.
- R3: When `frac_en` is 1, the product is multiplied by two (shifted left one bit, zero into the LSB) before it is used. When `frac_en` is 0, the product is used unshifted.
- R4: With `acc_en` high and `clr` low, the product is added to the accumulator, or subtracted when `sub_en` is 1. When both strobes are low, the accumulator holds.
- R5: The accumulator is 40 bits wide. Sums that leave the 32-bit range but stay inside 40 bits are kept exactly and give the correct value when brought back into range.
- R6: `qnt_sel` = 0 (and the spare code 3) rounds half up: the result is floor((acc + 2^15) / 2^16). For example -0.25 LSB becomes 0 and -0.75 LSB becomes -1.
- R7: `qnt_sel` = 1 truncates toward minus infinity: floor(acc / 2^16). Both -0.25 and -0.75 LSB become -1.
- R8: `qnt_sel` = 2 truncates toward zero. Both -0.25 and -0.75 LSB become 0.
- R9: `ovf_sel` = 0 (and the spare code 3) saturates an out-of-range value to 0x7FFF when it is positive and to 0x8000 when it is negative.
- R10: `ovf_sel` = 1 outputs 0 on overflow.
- R11: `ovf_sel` = 2 wraps: the result is the low 16 bits of the quantized value.
- R12: `ovf` is 1 exactly when the quantized value lies outside -32768..32767.
- R13: A strobe sampled at clock edge k changes the accumulator at edge k. The `res`/`ovf` pair captured at edge k+1 reflects that accumulator, using the `qnt_sel`/`ovf_sel` values present at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 16 | Signed multiplicand |
| op_b | input | 16 | Signed multiplier |
| frac_en | input | 1 | Double the product (fractional operands) |
| sub_en | input | 1 | Subtract the product instead of adding it |
| clr | input | 1 | Load the product into the accumulator |
| acc_en | input | 1 | Accumulate the product |
| qnt_sel | input | 2 | Quantization rule: 0 round, 1 floor, 2 toward zero, 3 round |
| ovf_sel | input | 2 | Overflow rule: 0 saturate, 1 zero, 2 wrap, 3 saturate |
| res | output | 16 | Registered quantized result |
| ovf | output | 1 | Registered overflow flag for `res` |

## Verification
A strobe at one rising edge updates the accumulator at that edge. Its quantized value appears on `res` and `ovf` only after the following edge, and that output uses the mode selects present at the second edge. The bench model mirrors this with two steps at each rising edge. It first forms the expected output from the accumulator value held before the edge, and only then applies that edge's strobe to its own accumulator. The design outputs are compared against this model at every falling edge. Each result is therefore judged exactly one edge after its accumulator value was formed, and a mode change is judged in the cycle it takes effect.

// File: rtl/fxp_mac_pkg.sv
package fxp_mac_pkg;

   typedef enum logic [1:0] {
      QNT_ROUND  = 2'd0,
      QNT_FLOOR  = 2'd1,
      QNT_TOZERO = 2'd2,
      QNT_SPARE  = 2'd3
   } qnt_mode_e;

   typedef enum logic [1:0] {
      OVF_SAT   = 2'd0,
      OVF_ZERO  = 2'd1,
      OVF_WRAP  = 2'd2,
      OVF_SPARE = 2'd3
   } ovf_mode_e;

endpackage

// File: rtl/fxp_mult.sv
// Signed multiplier with optional fractional one-bit left shift,
// product sign-extended to the accumulator width.
module fxp_mult #(
   parameter int OP_W     = 16,
   parameter int ACC_W    = 40,
   parameter bit FRAC_OPT = 1'b1
) (
   input  logic signed [OP_W-1:0]  mul_a,
   input  logic signed [OP_W-1:0]  mul_b,
   input  logic                    dbl_en,
   output logic signed [ACC_W-1:0] prod_ext
);
   localparam int PROD_W = 2 * OP_W;

   logic signed [PROD_W-1:0] prod_raw;
   logic signed [ACC_W-1:0]  prod_wide;

   assign prod_raw  = PROD_W'(mul_a) * PROD_W'(mul_b);
   assign prod_wide = ACC_W'(prod_raw);

   generate
      if (FRAC_OPT) begin : g_frac
         assign prod_ext = dbl_en ? (prod_wide <<< 1) : prod_wide;
      end else begin : g_int
         logic unused_dbl;
         assign unused_dbl = dbl_en;
         assign prod_ext   = prod_wide;
      end
   endgenerate
endmodule

// File: rtl/fxp_accum.sv
// Guard-bit accumulator: load, add, subtract or hold in one cycle.
module fxp_accum #(
   parameter int ACC_W = 40
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load_en,
   input  logic                    add_en,
   input  logic                    neg_en,
   input  logic signed [ACC_W-1:0] term,
   output logic signed [ACC_W-1:0] acc_q
);
   logic signed [ACC_W-1:0] addend;
   logic signed [ACC_W-1:0] acc_d;

   assign addend = neg_en ? -term : term;

   always_comb begin
      if (load_en)
         acc_d = addend;
      else if (add_en)
         acc_d = acc_q + addend;
      else
         acc_d = acc_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc_q <= '0;
      else
         acc_q <= acc_d;
   end
endmodule

// File: rtl/fxp_quant.sv
// Drops DROP_W low bits of the accumulator with the selected rule.
// The result is one bit wider than the kept field so that a
// rounding carry can never wrap.
module fxp_quant #(
   parameter int ACC_W  = 40,
   parameter int DROP_W = 16,
   localparam int QW    = ACC_W - DROP_W + 1
) (
   input  logic signed [ACC_W-1:0] acc,
   input  logic [1:0]              mode,
   output logic signed [QW-1:0]    qval
);
   import fxp_mac_pkg::*;

   logic signed [ACC_W:0]  acc_x;
   logic signed [QW-1:0]   floor_v;
   logic [DROP_W-1:0]      dropped;
   logic                   half_bit;
   logic                   inexact_neg;
   qnt_mode_e              qm;

   assign acc_x       = {acc[ACC_W-1], acc};
   assign floor_v     = acc_x[ACC_W:DROP_W];
   assign dropped     = acc[DROP_W-1:0];
   assign half_bit    = dropped[DROP_W-1];
   assign inexact_neg = acc[ACC_W-1] & (|dropped);
   assign qm          = qnt_mode_e'(mode);

   always_comb begin
      unique case (qm)
         QNT_FLOOR:  qval = floor_v;
         QNT_TOZERO: qval = floor_v + QW'(inexact_neg);
         default:    qval = floor_v + QW'(half_bit);
      endcase
   end
endmodule

// File: rtl/fxp_ovf.sv
// Fits a quantized value into OUT_W bits with the selected overflow rule.
module fxp_ovf #(
   parameter int QW    = 25,
   parameter int OUT_W = 16
) (
   input  logic signed [QW-1:0]    qval,
   input  logic [1:0]              mode,
   output logic [OUT_W-1:0]        fit,
   output logic                    over
);
   import fxp_mac_pkg::*;

   localparam int TOP_W = QW - OUT_W + 1;
   localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] NEG_MAX = {1'b1, {(OUT_W-1){1'b0}}};

   logic [TOP_W-1:0] top_bits;
   ovf_mode_e        om;

   assign top_bits = qval[QW-1:OUT_W-1];
   assign over     = ~((&top_bits) | ~(|top_bits));
   assign om       = ovf_mode_e'(mode);

   always_comb begin
      if (!over)
         fit = qval[OUT_W-1:0];
      else begin
         unique case (om)
            OVF_ZERO: fit = '0;
            OVF_WRAP: fit = qval[OUT_W-1:0];
            default:  fit = qval[QW-1] ? NEG_MAX : POS_MAX;
         endcase
      end
   end
endmodule

// File: rtl/fxp_mac_quant.sv
module fxp_mac_quant #(
   parameter int OP_W     = 16,
   parameter int GUARD_W  = 8,
   parameter bit FRAC_OPT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OP_W-1:0]  op_a,
   input  logic [OP_W-1:0]  op_b,
   input  logic             frac_en,
   input  logic             sub_en,
   input  logic             clr,
   input  logic             acc_en,
   input  logic [1:0]       qnt_sel,
   input  logic [1:0]       ovf_sel,
   output logic [OP_W-1:0]  res,
   output logic             ovf
);
   localparam int ACC_W  = 2 * OP_W + GUARD_W;
   localparam int DROP_W = OP_W;
   localparam int QW     = ACC_W - DROP_W + 1;

   generate
      if (OP_W < 2) begin : g_bad_op
         $error("fxp_mac_quant: OP_W must be at least 2");
      end
      if (GUARD_W < 0) begin : g_bad_guard
         $error("fxp_mac_quant: GUARD_W must not be negative");
      end
   endgenerate

   logic signed [ACC_W-1:0] prod_ext;
   logic signed [ACC_W-1:0] acc_q;
   logic signed [QW-1:0]    qval;
   logic [OP_W-1:0]         fit;
   logic                    over;

   fxp_mult #(.OP_W(OP_W), .ACC_W(ACC_W), .FRAC_OPT(FRAC_OPT)) u_mult (
      .mul_a   (op_a),
      .mul_b   (op_b),
      .dbl_en  (frac_en),
      .prod_ext(prod_ext)
   );

   fxp_accum #(.ACC_W(ACC_W)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_en(clr),
      .add_en (acc_en),
      .neg_en (sub_en),
      .term   (prod_ext),
      .acc_q  (acc_q)
   );

   fxp_quant #(.ACC_W(ACC_W), .DROP_W(DROP_W)) u_quant (
      .acc (acc_q),
      .mode(qnt_sel),
      .qval(qval)
   );

   fxp_ovf #(.QW(QW), .OUT_W(OP_W)) u_ovf (
      .qval(qval),
      .mode(ovf_sel),
      .fit (fit),
      .over(over)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res <= '0;
         ovf <= 1'b0;
      end else begin
         res <= fit;
         ovf <= over;
      end
   end
endmodule

// File: rtl/fxp_mac_chk.sv
module fxp_mac_chk #(
   parameter int OP_W  = 16,
   parameter int ACC_W = 40
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic             acc_en,
   input logic [OP_W-1:0]  op_a,
   input logic [1:0]       ovf_sel,
   input logic [OP_W-1:0]  res,
   input logic             ovf,
   input logic [ACC_W-1:0] acc
);
   localparam logic [OP_W-1:0] POS_MAX = {1'b0, {(OP_W-1){1'b1}}};
   localparam logic [OP_W-1:0] NEG_MAX = {1'b1, {(OP_W-1){1'b0}}};

   // R4
   hold_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !acc_en) |=> $stable(acc));

   // R2
   zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && op_a == '0) |=> (acc == '0));

   // R9
   sat_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && ($past(ovf_sel) == 2'd0 || $past(ovf_sel) == 2'd3))
         |-> (res == POS_MAX || res == NEG_MAX));

   // R10
   zero_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && $past(ovf_sel) == 2'd1) |-> (res == '0));
endmodule

bind fxp_mac_quant fxp_mac_chk #(.OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .clr    (clr),
   .acc_en (acc_en),
   .op_a   (op_a),
   .ovf_sel(ovf_sel),
   .res    (res),
   .ovf    (ovf),
   .acc    (acc_q)
);

// File: tb/sim_fxp_mac_quant.sv
`timescale 1ns/1ps
module sim_fxp_mac_quant;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] op_a = '0, op_b = '0;
   logic        frac_en = 0, sub_en = 0, clr = 0, acc_en = 0;
   logic [1:0]  qnt_sel = 0, ovf_sel = 0;
   logic [15:0] res;
   logic        ovf;

   int    checks = 0, errors = 0, cyc = 0;
   string cur_req = "R1";
   bit    chk_on = 0, done = 0;

   longint      m_acc = 0;
   logic [15:0] exp_res = '0;
   logic        exp_ovf = 1'b0;

   always #2 clk = ~clk;

   fxp_mac_quant u0 (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
      .frac_en(frac_en), .sub_en(sub_en), .clr(clr), .acc_en(acc_en),
      .qnt_sel(qnt_sel), .ovf_sel(ovf_sel), .res(res), .ovf(ovf)
   );

   // Reference model: output from the old accumulator, then update it.
   always @(posedge clk) begin : model
      longint fl, q, pr, lowb;
      bit of;
      if (!rst_n) begin
         m_acc = 0; exp_res = '0; exp_ovf = 1'b0;
      end else begin
         fl   = m_acc >>> 16;
         lowb = m_acc & 64'hFFFF;
         case (qnt_sel)
            2'd1:    q = fl;
            2'd2:    q = (m_acc < 0 && lowb != 0) ? fl + 1 : fl;
            default: q = (m_acc + 32768) >>> 16;
         endcase
         of = (q > 32767) || (q < -32768);
         if (!of) exp_res = q[15:0];
         else case (ovf_sel)
            2'd1:    exp_res = 16'h0000;
            2'd2:    exp_res = q[15:0];
            default: exp_res = (q < 0) ? 16'h8000 : 16'h7FFF;
         endcase
         exp_ovf = of;
         pr = longint'($signed(op_a)) * longint'($signed(op_b));
         if (frac_en) pr = pr * 2;
         if (sub_en)  pr = -pr;
         if (clr)         m_acc = pr;
         else if (acc_en) m_acc = m_acc + pr;
         m_acc = (m_acc <<< 24) >>> 24;
      end
   end

   always @(negedge clk) begin
      if (chk_on && !done) begin
         checks++;
         if (res !== exp_res || ovf !== exp_ovf) begin
            errors++;
            $display("FAIL %s: res=%h ovf=%b expected res=%h ovf=%b",
                     cur_req, res, ovf, exp_res, exp_ovf);
         end
      end
   end

   task automatic finish_run();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         errors++;
         $display("FAIL watchdog: cycles=%0d expected completion", cyc);
         finish_run();
      end
   end

   task automatic op(input logic [15:0] a, input logic [15:0] b,
                     input bit fr, input bit sb, input bit cl, input bit en);
      @(negedge clk);
      op_a = a; op_b = b; frac_en = fr; sub_en = sb; clr = cl; acc_en = en;
   endtask

   task automatic idle(input int n);
      op(16'h0, 16'h0, 0, 0, 0, 0);
      repeat (n - 1) @(negedge clk);
   endtask

   task automatic modes(input logic [1:0] qs, input logic [1:0] os, input string tag);
      @(negedge clk);
      qnt_sel = qs; ovf_sel = os; cur_req = tag;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      checks++;
      if (res !== 16'h0 || ovf !== 1'b0) begin
         errors++;
         $display("FAIL R1: res=%h ovf=%b expected res=0000 ovf=0", res, ovf);
      end
      rst_n = 1'b1;
      chk_on = 1;
      idle(2);

      // R2 integer load; R13 latency judged every cycle
      cur_req = "R2";
      op(16'd300, 16'd500, 0, 0, 1, 0);
      cur_req = "R13";
      idle(3);
      cur_req = "R2";
      op(16'hFFFF, 16'h4000, 0, 0, 1, 1);  // -0.25 LSB, clr beats acc_en
      idle(2);
      // R6 R7 R8 on -0.25
      modes(2'd0, 2'd0, "R6");
      modes(2'd1, 2'd0, "R7");
      modes(2'd2, 2'd0, "R8");
      modes(2'd3, 2'd0, "R6");
      // -0.75 LSB
      op(16'hFFFD, 16'h4000, 0, 0, 1, 0);
      idle(2);
      modes(2'd0, 2'd0, "R6");
      modes(2'd1, 2'd0, "R7");
      modes(2'd2, 2'd0, "R8");
      modes(2'd0, 2'd0, "R6");

      // R3 fractional doubling
      cur_req = "R3";
      op(16'h4000, 16'h4000, 1, 0, 1, 0);
      idle(2);
      op(16'h4000, 16'h4000, 0, 0, 1, 0);
      idle(2);

      // R4 add, subtract, hold
      cur_req = "R4";
      op(16'h2000, 16'h4000, 1, 0, 0, 1);
      op(16'h1000, 16'h4000, 1, 1, 0, 1);
      idle(3);
      op(16'h1234, 16'h0200, 0, 1, 0, 1);
      idle(2);

      // R5 guard bits: swing to about +4.0 and back
      cur_req = "R5";
      op(16'h0100, 16'h0100, 1, 0, 1, 0);
      repeat (4) op(16'h7FFF, 16'h7FFF, 1, 0, 0, 1);
      repeat (4) op(16'h7FFF, 16'h7FFF, 1, 1, 0, 1);
      idle(2);

      // R9 R10 R11 R12 positive overflow: (-1)*(-1) fractional
      op(16'h8000, 16'h8000, 1, 0, 1, 0);
      idle(2);
      modes(2'd0, 2'd0, "R9");
      modes(2'd0, 2'd1, "R10");
      modes(2'd0, 2'd2, "R11");
      modes(2'd0, 2'd3, "R12");
      // negative overflow near -2.0
      op(16'h8000, 16'h7FFF, 1, 0, 1, 0);
      op(16'h8000, 16'h7FFF, 1, 0, 0, 1);
      idle(2);
      modes(2'd1, 2'd0, "R9");
      modes(2'd1, 2'd1, "R10");
      modes(2'd2, 2'd2, "R11");
      modes(2'd0, 2'd3, "R12");

      // mixed traffic, all modes
      cur_req = "R13";
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         op_a = 16'($urandom); op_b = 16'($urandom);
         frac_en = 1'($urandom); sub_en = 1'($urandom);
         clr = ($urandom % 8) == 0; acc_en = 1'($urandom);
         qnt_sel = 2'($urandom); ovf_sel = 2'($urandom);
      end
      idle(3);
      finish_run();
   end
endmodule